// File: doc/BRIEF.md
# Signed Exponent Detector with Two-Word Chaining

This block measures how far a 16-bit two's-complement word sits below full scale. Each strobed operation counts the redundant sign bits of the input word and stores the negated count in a held, signed exponent register. A later shifter stage can use that register to normalise the word. The register keeps its value between operations. A narrow mode input chooses how each operation treats the word and the exponent already held.

A 32-bit value is measured in two passes. The upper word goes first and sets the exponent. The lower word goes second and only changes the exponent when the upper word was nothing but sign bits. In that case the lower word's leading bits that match the upper word's sign extend the count, so the exponent can reach -31. A third mode accepts a word that came out of an adder together with that adder's overflow and carry flags. When the overflow flag is set, the block reports +1, which stands for a one-place right shift that restores the true sign. When the overflow flag is clear, this mode gives the same result as the plain upper-word mode.

Top module: `exp_detect`

## Requirements
- R1: A synchronous reset clears the exponent output to 0. It takes effect at the clock edge where reset is high, even when a strobe is present.
- R2: When the strobe is low, the exponent output keeps its value whatever the other inputs do.
- R3: In upper mode (op_mode 2'b00), a strobe loads minus the number of redundant sign bits of op_word. The leading sign bit itself is not counted. The result lies between 0 and -15, and a word made only of sign bits gives -15.
- R4: In lower mode (op_mode 2'b01), when the exponent equals -15, a strobe loads -15 minus the number of leading bits of op_word that equal bit 15 of the most recent upper-mode or non-overflowed overflow-mode word. A word made only of that bit gives -31.
- R5: In lower mode, when the exponent is not -15, a strobe leaves the exponent unchanged.
- R6: In overflow mode (op_mode 2'b10) with alu_ovf high, a strobe loads +1.
- R7: In overflow mode with alu_ovf low, a strobe gives exactly the upper-mode result. alu_carry never changes the exponent in any mode.
- R8: The reserved mode code 2'b11 leaves the exponent unchanged.
- R9: The exponent output is a 6-bit two's-complement value that changes at the clock edge where the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_mode | input | 2 | 00 upper, 01 lower, 10 overflow-corrected upper, 11 reserved |
| op_word | input | 16 | Two's-complement word to measure |
| alu_ovf | input | 1 | Adder overflow flag |
| alu_carry | input | 1 | Adder carry, the true sign when overflow is set |
| exp_out | output | 6 | Held signed exponent |

## Verification
The range and hold properties assume that op_mode, op_word and the flags are stable and known at every edge where op_valid is high. The bench meets this by changing inputs only on falling edges. The lower-word properties assume only that the exponent already held is a legal value, because the lower-word rule depends on it. The stimulus always sets that value with an upper-word pass, or with reset, before any lower-word pass. The flags are swept freely in every mode, including combinations that an adder would never produce, such as a carry toggling while overflow is low.

// File: rtl/exp_det_pkg.sv
package exp_det_pkg;

   typedef enum logic [1:0] {
      MODE_UPPER     = 2'b00,
      MODE_LOWER     = 2'b01,
      MODE_UPPER_OVF = 2'b10,
      MODE_RSVD      = 2'b11
   } exp_mode_e;

endpackage

// File: rtl/exp_lead_run.sv
// Counts how many bits, starting at the MSB, match ref_bit before the first
// mismatch. The result is in the range 0..W.
module exp_lead_run #(
   parameter  int W  = 16,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  word,
   input  logic          ref_bit,
   output logic [CW-1:0] run
);

   logic [W:0] chain;
   assign chain[W] = 1'b1;

   for (genvar i = W - 1; i >= 0; i--) begin : g_chain
      assign chain[i] = chain[i+1] & (word[i] == ref_bit);
   end

   always_comb begin
      run = '0;
      for (int i = 0; i < W; i++) begin
         run = run + CW'(chain[i]);
      end
   end

endmodule

// File: rtl/exp_next.sv
// Chooses the next exponent and the next remembered upper-word sign.
module exp_next
   import exp_det_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SE_W   = 6
) (
   input  logic [1:0]              mode,
   input  logic [DATA_W-1:0]       word,
   input  logic                    ovf,
   input  logic                    carry,
   input  logic signed [SE_W-1:0]  se_q,
   input  logic                    sign_q,
   output logic signed [SE_W-1:0]  se_d,
   output logic                    sign_d
);

   localparam int CW = $clog2(DATA_W + 1);
   localparam logic signed [SE_W-1:0] SE_FULL = SE_W'(1 - DATA_W);
   localparam logic signed [SE_W-1:0] SE_ONE  = SE_W'(1);

   exp_mode_e       mode_e;
   logic            ref_bit;
   logic [CW-1:0]   run;

   assign mode_e  = exp_mode_e'(mode);
   assign ref_bit = (mode_e == MODE_LOWER) ? sign_q : word[DATA_W-1];

   exp_lead_run #(.W(DATA_W)) u_run (
      .word    (word),
      .ref_bit (ref_bit),
      .run     (run)
   );

   always_comb begin
      se_d   = se_q;
      sign_d = sign_q;
      case (mode_e)
         MODE_UPPER: begin
            se_d   = SE_ONE - SE_W'(run);
            sign_d = word[DATA_W-1];
         end
         MODE_UPPER_OVF: begin
            if (ovf) begin
               se_d   = SE_ONE;
               sign_d = carry;
            end else begin
               se_d   = SE_ONE - SE_W'(run);
               sign_d = word[DATA_W-1];
            end
         end
         MODE_LOWER: begin
            if (se_q == SE_FULL) begin
               se_d = SE_FULL - SE_W'(run);
            end
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/exp_state.sv
// Holds the exponent and the sign of the last upper word.
module exp_state #(
   parameter int SE_W = 6
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  logic signed [SE_W-1:0]  se_d,
   input  logic                    sign_d,
   output logic signed [SE_W-1:0]  se_q,
   output logic                    sign_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         se_q   <= '0;
         sign_q <= 1'b0;
      end else if (load) begin
         se_q   <= se_d;
         sign_q <= sign_d;
      end
   end

endmodule

// File: rtl/exp_detect.sv
module exp_detect #(
   parameter int DATA_W = 16,
   parameter int SE_W   = 6
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    op_valid,
   input  logic [1:0]              op_mode,
   input  logic [DATA_W-1:0]       op_word,
   input  logic                    alu_ovf,
   input  logic                    alu_carry,
   output logic signed [SE_W-1:0]  exp_out
);

   localparam logic signed [SE_W-1:0] SE_ZERO = '0;
   localparam logic signed [SE_W-1:0] SE_ONE  = SE_W'(1);
   localparam logic signed [SE_W-1:0] SE_FULL = SE_W'(1 - DATA_W);
   localparam logic signed [SE_W-1:0] SE_DEEP = SE_W'(1 - 2 * DATA_W);

   if (DATA_W < 2) begin : g_bad_width
      $error("exp_detect: DATA_W must be at least 2");
   end
   if (SE_W < $clog2(2 * DATA_W) + 1) begin : g_bad_se
      $error("exp_detect: SE_W too narrow for a two-word exponent");
   end

   logic signed [SE_W-1:0] se_d;
   logic signed [SE_W-1:0] se_q;
   logic                   sign_d;
   logic                   sign_q;

   exp_next #(.DATA_W(DATA_W), .SE_W(SE_W)) u_next (
      .mode   (op_mode),
      .word   (op_word),
      .ovf    (alu_ovf),
      .carry  (alu_carry),
      .se_q   (se_q),
      .sign_q (sign_q),
      .se_d   (se_d),
      .sign_d (sign_d)
   );

   exp_state #(.SE_W(SE_W)) u_state (
      .clk    (clk),
      .rst    (rst),
      .load   (op_valid),
      .se_d   (se_d),
      .sign_d (sign_d),
      .se_q   (se_q),
      .sign_q (sign_q)
   );

   assign exp_out = se_q;

   a_r1_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (exp_out == SE_ZERO));

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> $stable(exp_out));

   a_r3_upper_range: assert property (@(posedge clk) disable iff (rst)
      op_valid && (op_mode == 2'b00) |=> (exp_out <= SE_ZERO) && (exp_out >= SE_FULL));

   a_r4_lower_range: assert property (@(posedge clk) disable iff (rst)
      op_valid && (op_mode == 2'b01) && (exp_out == SE_FULL)
      |=> (exp_out <= SE_FULL) && (exp_out >= SE_DEEP));

   a_r5_lower_hold: assert property (@(posedge clk) disable iff (rst)
      op_valid && (op_mode == 2'b01) && (exp_out != SE_FULL) |=> $stable(exp_out));

   a_r6_ovf_one: assert property (@(posedge clk) disable iff (rst)
      op_valid && (op_mode == 2'b10) && alu_ovf |=> (exp_out == SE_ONE));

   a_r7_no_ovf_range: assert property (@(posedge clk) disable iff (rst)
      op_valid && (op_mode == 2'b10) && !alu_ovf
      |=> (exp_out <= SE_ZERO) && (exp_out >= SE_FULL));

   a_r8_rsvd_hold: assert property (@(posedge clk) disable iff (rst)
      op_valid && (op_mode == 2'b11) |=> $stable(exp_out));

endmodule

// File: tb/exp_detect_tb.sv
module exp_detect_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 180000;

   logic              clk = 1'b0;
   logic              rst;
   logic              op_valid;
   logic [1:0]        op_mode;
   logic [15:0]       op_word;
   logic              alu_ovf;
   logic              alu_carry;
   logic signed [5:0] exp_out;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   exp_detect u_dut (
      .clk       (clk),
      .rst       (rst),
      .op_valid  (op_valid),
      .op_mode   (op_mode),
      .op_word   (op_word),
      .alu_ovf   (alu_ovf),
      .alu_carry (alu_carry),
      .exp_out   (exp_out)
   );

   // Index of the highest set bit of m, or -1 when m is zero.
   function automatic int top_bit(input logic [15:0] m);
      int p = -1;
      for (int i = 0; i < 16; i++) if (m[i]) p = i;
      return p;
   endfunction

   function automatic int exp_upper(input logic [15:0] w);
      return top_bit(w[15] ? ~w : w) - 14;
   endfunction

   function automatic int exp_lower(input logic s, input logic [15:0] w);
      return top_bit(s ? ~w : w) - 30;
   endfunction

   task automatic chk(input string tag, input int got, input int want);
      total++;
      if (got != want) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, want);
      end
   endtask

   // Presents one strobed operation and returns at the next falling edge.
   task automatic do_op(input logic [1:0] m, input logic [15:0] w,
                        input logic v, input logic c);
      op_valid  = 1'b1;
      op_mode   = m;
      op_word   = w;
      alu_ovf   = v;
      alu_carry = c;
      @(negedge clk);
   endtask

   task automatic go_idle();
      op_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; op_valid = 1'b0; op_mode = 2'b00; op_word = '0;
      alu_ovf = 1'b0; alu_carry = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset value", int'(exp_out), 0);
      rst = 1'b0;

      // R3: all words in upper mode; flags vary and must not matter.
      for (int w = 0; w < 65536; w++) begin
         do_op(2'b00, 16'(w), w[3], w[7]);
         chk("R3 upper sweep", int'(exp_out), exp_upper(16'(w)));
      end
      do_op(2'b00, 16'hF6D4, 1'b0, 1'b0);
      chk("R3 example -3", int'(exp_out), -3);
      do_op(2'b00, 16'hFFFF, 1'b0, 1'b0);
      chk("R3 all sign", int'(exp_out), -15);

      // R7: overflow mode with overflow clear matches upper mode; carry ignored.
      for (int w = 0; w < 65536; w += 3) begin
         do_op(2'b10, 16'(w), 1'b0, w[0]);
         chk("R7 no-overflow sweep", int'(exp_out), exp_upper(16'(w)));
      end
      do_op(2'b10, 16'hE35B, 1'b0, 1'b1);
      chk("R7 example -2", int'(exp_out), -2);

      // R6: overflow set gives +1 whatever the word or carry.
      for (int w = 0; w < 65536; w += 11) begin
         do_op(2'b10, 16'(w), 1'b1, w[1]);
         chk("R6 overflow sweep", int'(exp_out), 1);
      end

      // R4: lower word continues the count after an all-sign upper word.
      for (int s = 0; s < 2; s++) begin
         for (int w = 0; w < 65536; w += 7) begin
            do_op(2'b00, (s != 0) ? 16'hFFFF : 16'h0000, 1'b0, 1'b0);
            chk("R4 setup upper", int'(exp_out), -15);
            do_op(2'b01, 16'(w), w[2], w[5]);
            chk("R4 lower sweep", int'(exp_out), exp_lower(s[0], 16'(w)));
         end
      end
      do_op(2'b00, 16'hFFFF, 1'b0, 1'b0);
      do_op(2'b01, 16'hF6D4, 1'b0, 1'b0);
      chk("R4 example -19", int'(exp_out), -19);
      do_op(2'b00, 16'h0000, 1'b0, 1'b0);
      do_op(2'b01, 16'h0000, 1'b0, 1'b0);
      chk("R4 both halves zero", int'(exp_out), -31);
      do_op(2'b00, 16'hFFFF, 1'b0, 1'b0);
      do_op(2'b01, 16'hFFFF, 1'b0, 1'b0);
      chk("R4 both halves ones", int'(exp_out), -31);
      // Sign remembered from a non-overflowed overflow-mode word.
      do_op(2'b10, 16'h0000, 1'b0, 1'b1);
      do_op(2'b01, 16'h00FF, 1'b0, 1'b1);
      chk("R4 sign from overflow mode", int'(exp_out), -23);

      // R5: lower word does not move an exponent other than -15.
      for (int w = 0; w < 65536; w += 257) begin
         do_op(2'b00, 16'hF6D4, 1'b0, 1'b0);
         do_op(2'b01, 16'(w), 1'b0, 1'b0);
         chk("R5 lower hold", int'(exp_out), -3);
      end
      do_op(2'b00, 16'h0000, 1'b0, 1'b0);
      do_op(2'b01, 16'h0F00, 1'b0, 1'b0);
      chk("R5 setup -19", int'(exp_out), -19);
      do_op(2'b01, 16'h0000, 1'b0, 1'b0);
      chk("R5 second lower ignored", int'(exp_out), -19);

      // R2: no strobe, inputs toggling.
      do_op(2'b00, 16'h0001, 1'b0, 1'b0);
      chk("R9 loads at strobe edge", int'(exp_out), -14);
      op_valid = 1'b0;
      for (int k = 0; k < 6; k++) begin
         op_mode = 2'(k); op_word = 16'(k * 4099); alu_ovf = k[0]; alu_carry = k[1];
         @(negedge clk);
         chk("R2 idle hold", int'(exp_out), -14);
      end

      // R8: reserved mode holds.
      for (int k = 0; k < 8; k++) begin
         do_op(2'b11, 16'(k * 8191), k[0], k[1]);
         chk("R8 reserved hold", int'(exp_out), -14);
      end

      // R1: reset wins over a strobe.
      do_op(2'b10, 16'h1234, 1'b1, 1'b0);
      chk("R6 before reset", int'(exp_out), 1);
      rst = 1'b1;
      do_op(2'b00, 16'h0001, 1'b0, 1'b0);
      chk("R1 reset over strobe", int'(exp_out), 0);
      rst = 1'b0;
      go_idle();
      chk("R1 stays after reset", int'(exp_out), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule